// File: doc/BRIEF.md
# Transmit Sample Offload Buffer

This block sits in a transmit sample path and captures exactly one incoming stream transaction into a fixed-depth internal store. Playback does not start when the capture ends. It starts on a separate sync event. Once triggered, the block replays the stored beats in order on an output stream and marks the final beat. After the final beat it returns to idle and is ready for a new capture.

Capture never stalls the upstream source. If a transaction is longer than the store, the block keeps `s_ready` high until the beat marked last. It keeps the first `DEPTH` beats and silently drops the rest. Playback then presents the truncated transaction, with its end marker on the last stored beat.

The sync input can pass through an internal two-flop synchronizer, which is the default. It can also be used directly when it is already synchronous to `clk`, for example when one synchronous sync line is shared between several buffers. A sync event is a rising edge of the (synchronized) sync level.

Both streams follow valid/ready rules:
- A beat transfers on a clock edge where valid and ready are both high.
- The output holds its valid, data and end marker steady while `m_ready` is low.
- The input is not ready while the block waits for sync or plays back.

Top module: `txbuf_offload`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_valid` is 0.
- R2: Beats captured in one transaction are replayed on `m_data` in arrival order. `m_last` is 1 on the final replayed beat and on no other beat.
- R3: While capturing, `s_ready` stays 1 after the store is full, until the beat with `s_last`=1 has been accepted.
- R4: A transaction of more than `DEPTH` beats is replayed as only its first `DEPTH` beats, with `m_last`=1 on beat number `DEPTH`. A transaction of exactly `DEPTH` beats is replayed whole.
- R5: After a capture completes, `m_valid` stays 0 until a sync event.
- R6: A sync event during capture is remembered. Playback starts after the last beat is accepted, with no further sync.
- R7: A sync event while idle is ignored. A later capture waits for a new sync event.
- R8: `s_ready` is 0 while waiting for sync and throughout playback.
- R9: While `m_valid`=1 and `m_ready`=0, `m_valid`, `m_data` and `m_last` hold their values into the next cycle.
- R10: With `INTERNAL_SYNC`=1, a rising edge on `sync_in` in the wait state makes `m_valid` rise three clock edges later. With `INTERNAL_SYNC`=0, it rises one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Playback trigger level; its rising edge is the event |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with `s_valid` |
| s_data | input | DATA_W | Input sample data |
| s_last | input | 1 | Final beat of the input transaction |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Output sample data |
| m_last | output | 1 | Final stored beat of the playback |

## Verification
The assertions assume the following about the inputs:
- Reset is held for at least one edge.
- `m_ready` is an ordinary level that may drop at any time.
- Every transaction ends with a beat marked last.

Under these assumptions, the only rule on `s_last` that the checker relies on is that `s_ready` stays high between the first and last beats. The stimulus closes every transaction with `s_last` and drains each playback before driving a new capture. It moves `m_ready` only shortly after a rising edge and drives `sync_in` as one-cycle pulses away from the edge. As a result, no check depends on how processes are ordered at the sampling edge.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_READ  = 2'd3
  } txbuf_state_e;
endpackage

// File: rtl/txbuf_sync_in.sv
module txbuf_sync_in #(
  parameter int INTERNAL_SYNC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic sync_evt
);
  logic lvl;
  logic lvl_q;

  generate
    if (INTERNAL_SYNC != 0) begin : g_cdc
      logic [1:0] shreg;
      always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[0], sync_in};
      end
      assign lvl = shreg[1];
    end else begin : g_direct
      assign lvl = sync_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  // One-cycle event on a rising level
  assign sync_evt = lvl & ~lvl_q;
endmodule

// File: rtl/txbuf_store.sv
module txbuf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_evt,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              m_ready,
  output logic              m_valid,
  output logic              m_last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output txbuf_state_e      state_o,
  output logic [CNT_W-1:0]  fill_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  txbuf_state_e     state;
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] rd_ptr;
  logic             pend;
  logic             accept;
  logic             room;

  always_comb begin
    s_ready = (state == ST_IDLE) || (state == ST_WRITE);
    accept  = s_valid && s_ready;
    room    = fill < CAP;
    wr_en   = accept && room;
    wr_addr = fill[ADDR_W-1:0];
    rd_addr = rd_ptr[ADDR_W-1:0];
    m_valid = (state == ST_READ);
    m_last  = m_valid && (rd_ptr == fill - ONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      fill   <= '0;
      rd_ptr <= '0;
      pend   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          pend <= 1'b0;
          if (accept) begin
            if (room) fill <= fill + ONE;
            state <= s_last ? ST_WAIT : ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (sync_evt) pend <= 1'b1;
          if (accept) begin
            if (room) fill <= fill + ONE;
            if (s_last) state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (pend || sync_evt) begin
            state <= ST_READ;
            pend  <= 1'b0;
          end
        end
        ST_READ: begin
          if (m_ready) begin
            if (m_last) begin
              state  <= ST_IDLE;
              fill   <= '0;
              rd_ptr <= '0;
            end else begin
              rd_ptr <= rd_ptr + ONE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state;
  assign fill_o  = fill;
endmodule

// File: rtl/txbuf_offload.sv
module txbuf_offload
  import txbuf_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int DEPTH         = 16,
  parameter int INTERNAL_SYNC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              sync_evt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  txbuf_state_e      state;
  logic [CNT_W-1:0]  fill;

  txbuf_sync_in #(.INTERNAL_SYNC(INTERNAL_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_evt(sync_evt)
  );

  txbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt),
    .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .m_ready(m_ready), .m_valid(m_valid), .m_last(m_last),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .state_o(state), .fill_o(fill)
  );

  txbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(s_data),
    .rd_addr(rd_addr), .rd_data(m_data)
  );
endmodule

// File: rtl/txbuf_offload_chk.sv
module txbuf_offload_chk
  import txbuf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_last,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last,
  input txbuf_state_e      state,
  input logic [CNT_W-1:0]  fill
);
  a_r3_keep_consuming: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && !s_last |=> s_ready);

  a_r4_fill_capped: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  a_r2_last_ends_playback: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last |=> !m_valid);

  a_r7_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |=> !m_valid);

  a_r8_input_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));
endmodule

bind txbuf_offload txbuf_offload_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_last(m_last), .state(state), .fill(fill)
);

// File: tb/sim_txbuf_offload.sv
module sim_txbuf_offload;
  localparam int DW    = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_last = 1'b0;
  logic m_ready = 1'b1;
  logic s_ready, m_valid, m_last;
  logic [DW-1:0] m_data;
  logic b_s_ready, b_m_valid, b_m_last;
  logic [DW-1:0] b_m_data;

  always #5 clk = ~clk;

  txbuf_offload #(.DATA_W(DW), .DEPTH(DEPTH), .INTERNAL_SYNC(1)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_last(m_last));

  txbuf_offload #(.DATA_W(DW), .DEPTH(DEPTH), .INTERNAL_SYNC(0)) u1 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .s_valid(s_valid),
    .s_ready(b_s_ready), .s_data(s_data), .s_last(s_last), .m_valid(b_m_valid),
    .m_ready(1'b1), .m_data(b_m_data), .m_last(b_m_last));

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit bp_en = 0;
  int cyc = 0;

  logic [DW-1:0] exp_data[$];
  bit            exp_last[$];
  string         exp_tag[$];

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Downstream ready, changed shortly after the edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 m_ready <= bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // Monitor: scoreboard compare plus R8/R9 at the output
  logic          prev_stall = 0;
  logic [DW-1:0] prev_data;
  logic          prev_last;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(m_valid && m_data == prev_data && m_last == prev_last, "R9",
            {m_valid, m_last, m_data}, {1'b1, prev_last, prev_data});
      end
      if (m_valid) begin
        chk(s_ready == 1'b0, "R8", s_ready, 0);
        if (m_ready) begin
          if (exp_data.size() == 0) begin
            chk(0, "R2 unexpected beat", m_data, 0);
          end else begin
            string tg;
            logic [DW-1:0] ed;
            bit el;
            ed = exp_data.pop_front();
            el = exp_last.pop_front();
            tg = exp_tag.pop_front();
            chk(m_data == ed && m_last == el, tg, {m_last, m_data}, {el, ed});
          end
        end
      end
      prev_stall = m_valid && !m_ready;
      prev_data  = m_data;
      prev_last  = m_last;
    end
  end

  task automatic send_txn(int n, int base, int gap, string tag);
    int keep = (n < DEPTH) ? n : DEPTH;
    for (int i = 0; i < keep; i++) begin
      exp_data.push_back(DW'(base + i));
      exp_last.push_back(i == keep - 1);
      exp_tag.push_back(tag);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = DW'(base + i);
      s_last  = (i == n - 1);
      if (i >= DEPTH) chk(s_ready == 1'b1, "R3", s_ready, 1);
      while (!s_ready) @(negedge clk);
      @(posedge clk);
      if (gap > 0) begin
        @(negedge clk);
        s_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic drain();
    while (exp_data.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R1", s_ready, 1);
    chk(m_valid == 1'b0, "R1", m_valid, 0);

    // Basic capture, wait, play
    send_txn(5, 16'h0100, 0, "R2");
    repeat (6) @(negedge clk);
    chk(m_valid == 1'b0, "R5", m_valid, 0);
    chk(s_ready == 1'b0, "R8", s_ready, 0);
    pulse_sync();
    drain();
    chk(s_ready == 1'b1, "R2 back to idle", s_ready, 1);

    // Oversized transaction: consumed whole, replayed truncated
    send_txn(DEPTH + 7, 16'h0200, 0, "R4");
    pulse_sync();
    drain();

    // Exactly full
    send_txn(DEPTH, 16'h0300, 1, "R4");
    pulse_sync();
    drain();

    // Sync during capture is remembered
    fork
      send_txn(8, 16'h0400, 1, "R6");
      begin repeat (3) @(negedge clk); pulse_sync(); end
    join
    repeat (2) @(negedge clk);
    chk(m_valid == 1'b1, "R6", m_valid, 1);
    drain();

    // Sync while idle is ignored
    pulse_sync();
    repeat (5) @(negedge clk);
    send_txn(3, 16'h0500, 0, "R7");
    repeat (8) @(negedge clk);
    chk(m_valid == 1'b0, "R7", m_valid, 0);
    chk(exp_data.size() == 3, "R7 queue", exp_data.size(), 3);
    pulse_sync();
    drain();

    // Back-pressure on the output
    bp_en = 1;
    send_txn(DEPTH + 2, 16'h0600, 0, "R9");
    pulse_sync();
    drain();
    bp_en = 0;
    repeat (3) @(negedge clk);

    // Sync latency with and without the internal synchronizer
    send_txn(2, 16'h0700, 0, "R10");
    repeat (4) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    chk(b_m_valid == 1'b1, "R10 bypass", b_m_valid, 1);
    chk(m_valid == 1'b0, "R10 sync edge1", m_valid, 0);
    sync_in = 1'b0;
    @(negedge clk);
    chk(m_valid == 1'b0, "R10 sync edge2", m_valid, 0);
    @(negedge clk);
    chk(m_valid == 1'b1, "R10 sync edge3", m_valid, 1);
    drain();

    chk(exp_data.size() == 0, "R2 all beats seen", exp_data.size(), 0);
    finish_run();
  end
endmodule